// File: doc/BRIEF.md
# Branch Target Buffer

This block is a small set-associative cache that fetch consults every cycle to decide where to go next. The fetch address is presented on the lookup port. If a stored branch matches, the block returns that branch's recorded destination in the same cycle, so fetch can redirect without a bubble. If nothing matches, the block predicts fall-through to the next sequential word. A matching entry only produces a taken prediction when its small saturating confidence counter says so. The stored target is still reported on the port in that case.

Resolved branches come back through the update port. An entry that already matches is refreshed: its target is rewritten and its counter is trained. A branch that misses gets a new entry only if it was actually taken. The new entry goes to an empty way of its set when one exists, and otherwise to the way used longest ago. Lookup reads the stored state combinationally and updates are written at the clock edge. A lookup that falls in the same cycle as an update therefore observes the buffer as it stood before that update.

Top module: `branch_target_buffer`

## Requirements
- R1: After reset every lookup misses: lkHit=0, lkTaken=0 and lkNextPc equals lkPc+4.
- R2: On a lookup miss, lkTaken is 0 and lkNextPc equals lkPc+4, wrapping modulo 2^32.
- R3: An update with upValid=1 and upTaken=1 for a PC that is not stored allocates an entry with counter value 2'b10. From the next cycle, a lookup of that PC returns lkHit=1, lkTaken=1, lkTarget equal to the given target, and lkNextPc equal to that target.
- R4: An update with upTaken=0 for a PC that is not stored allocates nothing. A later lookup of that PC still misses.
- R5: The set index is PC bits [5:2] and the tag is PC bits [31:6]. PC bits [1:0] are ignored on both ports. Two PCs with the same index but different tags never match each other.
- R6: An update whose PC matches a stored entry rewrites that entry's target, whether the branch was taken or not.
- R7: Each entry has a 2-bit saturating counter. A matching taken update increments it, up to a limit of 2'b11. A matching not-taken update decrements it, down to a limit of 2'b00. A hit predicts taken only when counter bit 1 is 1. On a hit with bit 1 at 0, lkHit=1, lkTarget shows the stored target, lkTaken=0 and lkNextPc=lkPc+4.
- R8: Each set holds 2 ways. An allocation uses the lowest-numbered empty way if the set has one, and otherwise the least recently used way. Every update that hits or allocates marks its way as most recently used. Lookups do not change recency.
- R9: When a lookup and an update are presented in the same cycle, the lookup result reflects the contents from before that update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lkPc | input | 32 | Fetch PC to look up |
| lkHit | output | 1 | A stored entry matches lkPc |
| lkTaken | output | 1 | Redirect predicted (hit and counter bit 1 set) |
| lkTarget | output | 32 | Stored target of the matching entry (meaningful when lkHit=1) |
| lkNextPc | output | 32 | Predicted next fetch address |
| upValid | input | 1 | A resolved branch is presented this cycle |
| upPc | input | 32 | PC of the resolved branch |
| upTarget | input | 32 | Resolved target address |
| upTaken | input | 1 | Resolved direction, 1 = taken |

## Verification
The hardest state to reach from the ports is a full set where the way to evict depends on the order in which earlier updates touched the two ways. Reaching it needs three distinct tags aimed at one index, with a refresh of the older entry placed between the fills. The directed phase builds exactly this order in all 16 sets. A pseudo-random phase then draws lookups and updates from a pool of four tags per set, in the same cycles, so evictions, counter saturation and same-cycle lookup/update collisions occur many times. Every cycle is compared against a behavioural model kept in the bench.

// File: rtl/btb_pkg.sv
package btb_pkg;

  localparam int NUM_WAYS = 2;

  // Strobes from control to datapath for one update cycle
  typedef struct packed {
    logic       wrEn;      // write target and counter of wrWay
    logic       alloc;     // also write tag and set valid
    logic       wrWay;     // way selected for the write
    logic [1:0] ctrNext;   // counter value to store
    logic       lruTouch;  // mark wrWay most recently used
  } btbStrobe_t;

endpackage

// File: rtl/btb_datapath.sv
module btb_datapath
  import btb_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int IDX_W  = 4,
  parameter bit USE_CTR = 1'b1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [PC_W-1:0]     lkPc,
  output logic                lkHit,
  output logic                lkTaken,
  output logic [PC_W-1:0]     lkTarget,
  output logic [PC_W-1:0]     lkNextPc,
  input  logic [PC_W-1:0]     upPc,
  input  logic [PC_W-1:0]     upTarget,
  output logic [NUM_WAYS-1:0] upHitVec,
  output logic [NUM_WAYS-1:0] upValidVec,
  output logic                upLruWay,
  output logic [1:0]          upHitCtr,
  input  btbStrobe_t          strobe
);
  localparam int SETS  = 1 << IDX_W;
  localparam int OFS   = 2;
  localparam int TAG_W = PC_W - IDX_W - OFS;

  logic [NUM_WAYS-1:0] validQ [SETS];
  logic [TAG_W-1:0]    tagQ   [SETS][NUM_WAYS];
  logic [PC_W-1:0]     tgtQ   [SETS][NUM_WAYS];
  logic [1:0]          ctrQ   [SETS][NUM_WAYS];
  logic [SETS-1:0]     lruQ;   // per set: way to evict next

  logic [IDX_W-1:0]    lkIdx, upIdx;
  logic [TAG_W-1:0]    lkTag, upTag;
  logic [NUM_WAYS-1:0] lkHitVec;
  logic [PC_W-1:0]     selTgt;
  logic                selHi;

  assign lkIdx = lkPc[OFS +: IDX_W];
  assign lkTag = lkPc[PC_W-1 -: TAG_W];
  assign upIdx = upPc[OFS +: IDX_W];
  assign upTag = upPc[PC_W-1 -: TAG_W];

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    assign lkHitVec[w]   = validQ[lkIdx][w] && (tagQ[lkIdx][w] == lkTag);
    assign upHitVec[w]   = validQ[upIdx][w] && (tagQ[upIdx][w] == upTag);
    assign upValidVec[w] = validQ[upIdx][w];
  end

  assign upLruWay = lruQ[upIdx];

  always_comb begin
    selTgt   = '0;
    selHi    = 1'b0;
    upHitCtr = 2'b00;
    for (int w = 0; w < NUM_WAYS; w++) begin
      if (lkHitVec[w]) begin
        selTgt = tgtQ[lkIdx][w];
        selHi  = ctrQ[lkIdx][w][1];
      end
      if (upHitVec[w]) upHitCtr = ctrQ[upIdx][w];
    end
  end

  assign lkHit    = |lkHitVec;
  assign lkTarget = selTgt;

  if (USE_CTR) begin : g_ctrGate
    assign lkTaken = lkHit && selHi;
  end else begin : g_hitOnly
    assign lkTaken = lkHit;
  end

  assign lkNextPc = lkTaken ? selTgt : lkPc + PC_W'(4);

  // Valid bits and recency, reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++) validQ[s] <= '0;
      lruQ <= '0;
    end else begin
      if (strobe.wrEn && strobe.alloc) validQ[upIdx][strobe.wrWay] <= 1'b1;
      if (strobe.lruTouch) lruQ[upIdx] <= ~strobe.wrWay;
    end
  end

  // Payload storage, not reset (guarded by valid)
  always_ff @(posedge clk) begin
    if (strobe.wrEn) begin
      tgtQ[upIdx][strobe.wrWay] <= upTarget;
      ctrQ[upIdx][strobe.wrWay] <= strobe.ctrNext;
      if (strobe.alloc) tagQ[upIdx][strobe.wrWay] <= upTag;
    end
  end

  // R5
  lk_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(lkHitVec));

  // R5
  same_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lkPc[PC_W-1:OFS] == upPc[PC_W-1:OFS]) |-> (lkHitVec == upHitVec));

  // R2
  miss_seq_chk: assert property (@(posedge clk) disable iff (!rstN)
    !lkHit |-> (!lkTaken && lkNextPc == lkPc + PC_W'(4)));

  // R7
  taken_needs_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
    lkTaken |-> lkHit);

  // R3
  alloc_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrEn && strobe.alloc) |=> validQ[$past(upIdx)][$past(strobe.wrWay)]);

  // R8
  lru_flip_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.lruTouch |=> (lruQ[$past(upIdx)] != $past(strobe.wrWay)));

endmodule

// File: rtl/btb_control.sv
module btb_control
  import btb_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                upValid,
  input  logic                upTaken,
  input  logic [NUM_WAYS-1:0] upHitVec,
  input  logic [NUM_WAYS-1:0] upValidVec,
  input  logic                upLruWay,
  input  logic [1:0]          upHitCtr,
  output btbStrobe_t          strobe
);
  logic anyHit, hitWay, victim;
  logic [1:0] trained;

  assign anyHit = |upHitVec;
  assign hitWay = upHitVec[1];

  always_comb begin
    if (!upValidVec[0])      victim = 1'b0;
    else if (!upValidVec[1]) victim = 1'b1;
    else                     victim = upLruWay;
  end

  always_comb begin
    if (upTaken) trained = (upHitCtr == 2'b11) ? 2'b11 : upHitCtr + 2'd1;
    else         trained = (upHitCtr == 2'b00) ? 2'b00 : upHitCtr - 2'd1;
  end

  always_comb begin
    strobe.alloc    = upValid && !anyHit && upTaken;
    strobe.wrEn     = upValid && (anyHit || upTaken);
    strobe.wrWay    = anyHit ? hitWay : victim;
    strobe.ctrNext  = anyHit ? trained : 2'b10;
    strobe.lruTouch = strobe.wrEn;
  end

  // R4
  no_nt_alloc_chk: assert property (@(posedge clk) disable iff (!rstN)
    (upValid && !upTaken && !anyHit) |-> !strobe.wrEn);

  // R8
  fill_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.alloc && !(&upValidVec)) |-> !upValidVec[strobe.wrWay]);

  // R7
  ctr_sat_chk: assert property (@(posedge clk) disable iff (!rstN)
    (upValid && anyHit && upTaken && upHitCtr == 2'b11) |-> strobe.ctrNext == 2'b11);

endmodule

// File: rtl/branch_target_buffer.sv
module branch_target_buffer
  import btb_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int IDX_W   = 4,
  parameter bit USE_CTR = 1'b1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [PC_W-1:0] lkPc,
  output logic            lkHit,
  output logic            lkTaken,
  output logic [PC_W-1:0] lkTarget,
  output logic [PC_W-1:0] lkNextPc,
  input  logic            upValid,
  input  logic [PC_W-1:0] upPc,
  input  logic [PC_W-1:0] upTarget,
  input  logic            upTaken
);
  btbStrobe_t          strobe;
  logic [NUM_WAYS-1:0] upHitVec, upValidVec;
  logic                upLruWay;
  logic [1:0]          upHitCtr;

  btb_datapath #(.PC_W(PC_W), .IDX_W(IDX_W), .USE_CTR(USE_CTR)) datapath_i (
    .clk(clk), .rstN(rstN),
    .lkPc(lkPc), .lkHit(lkHit), .lkTaken(lkTaken),
    .lkTarget(lkTarget), .lkNextPc(lkNextPc),
    .upPc(upPc), .upTarget(upTarget),
    .upHitVec(upHitVec), .upValidVec(upValidVec),
    .upLruWay(upLruWay), .upHitCtr(upHitCtr),
    .strobe(strobe)
  );

  btb_control control_i (
    .clk(clk), .rstN(rstN),
    .upValid(upValid), .upTaken(upTaken),
    .upHitVec(upHitVec), .upValidVec(upValidVec),
    .upLruWay(upLruWay), .upHitCtr(upHitCtr),
    .strobe(strobe)
  );

endmodule

// File: tb/branch_target_buffer_tb_top.sv
module branch_target_buffer_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] lkPc = '0, upPc = '0, upTarget = '0;
  logic        upValid = 1'b0, upTaken = 1'b0;
  logic        lkHit, lkTaken;
  logic [31:0] lkTarget, lkNextPc;

  int checks = 0, fails = 0;

  // reference state
  bit        mValid [16][2];
  bit [25:0] mTag   [16][2];
  bit [31:0] mTgt   [16][2];
  bit [1:0]  mCtr   [16][2];
  bit        mLru   [16];

  always #4 clk = ~clk;  // 125 MHz

  branch_target_buffer dut_i (
    .clk(clk), .rstN(rstN), .lkPc(lkPc), .lkHit(lkHit), .lkTaken(lkTaken),
    .lkTarget(lkTarget), .lkNextPc(lkNextPc), .upValid(upValid), .upPc(upPc),
    .upTarget(upTarget), .upTaken(upTaken)
  );

  function automatic int findWay(logic [31:0] pc);
    int s = int'(pc[5:2]);
    for (int w = 0; w < 2; w++)
      if (mValid[s][w] && mTag[s][w] == pc[31:6]) return w;
    return -1;
  endfunction

  task automatic modelUpdate(logic [31:0] pc, logic [31:0] tgt, logic tk);
    int s = int'(pc[5:2]);
    int w = findWay(pc);
    if (w >= 0) begin
      mTgt[s][w] = tgt;
      if (tk) mCtr[s][w] = (mCtr[s][w] == 2'd3) ? 2'd3 : mCtr[s][w] + 2'd1;
      else    mCtr[s][w] = (mCtr[s][w] == 2'd0) ? 2'd0 : mCtr[s][w] - 2'd1;
      mLru[s] = (w == 0);
    end else if (tk) begin
      w = !mValid[s][0] ? 0 : (!mValid[s][1] ? 1 : int'(mLru[s]));
      mValid[s][w] = 1'b1; mTag[s][w] = pc[31:6];
      mTgt[s][w] = tgt;    mCtr[s][w] = 2'd2;
      mLru[s] = (w == 0);
    end
  endtask

  task automatic checkLookup(string req);
    int  s = int'(lkPc[5:2]);
    int  w = findWay(lkPc);
    bit  eHit = (w >= 0);
    bit  eTk  = eHit && mCtr[s][w][1];
    logic [31:0] eNext = eTk ? mTgt[s][w] : lkPc + 32'd4;
    bit  bad = (lkHit !== eHit) || (lkTaken !== eTk) || (lkNextPc !== eNext) ||
               (eHit && lkTarget !== mTgt[s][w]);
    checks++;
    if (bad) begin
      fails++;
      $display("FAIL %s pc=%h: hit/taken/next/target = %0b/%0b/%h/%h expected %0b/%0b/%h/%h",
               req, lkPc, lkHit, lkTaken, lkNextPc, lkTarget, eHit, eTk, eNext,
               eHit ? mTgt[s][w] : lkTarget);
    end
  endtask

  // One cycle: drive at negedge, check lookup before the edge, commit model after it
  task automatic cycle(logic [31:0] lpc, logic doUp, logic [31:0] upc,
                       logic [31:0] tgt, logic tk, string req);
    @(negedge clk);
    lkPc = lpc; upValid = doUp; upPc = upc; upTarget = tgt; upTaken = tk;
    #1;
    checkLookup(req);
    @(posedge clk);
    if (doUp) modelUpdate(upc, tgt, tk);
    #1;
    upValid = 1'b0;
  endtask

  task automatic look(logic [31:0] pc, string req);
    cycle(pc, 1'b0, 32'h0, 32'h0, 1'b0, req);
  endtask

  task automatic upd(logic [31:0] pc, logic [31:0] tgt, logic tk);
    cycle(pc, 1'b1, pc, tgt, tk, "R9");
  endtask

  function automatic logic [31:0] mkPc(logic [25:0] tag, int idx, int low);
    return {tag, 4'(idx), 2'(low)};
  endfunction

  initial begin
    #(8 * 200000);
    fails++; checks++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] lfsr = 32'hACE1_2B3D;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1: everything misses after reset, including the wrapping address
    for (int s = 0; s < 16; s++) look(mkPc(26'h0001, s, 0), "R1");
    look(32'hFFFF_FFFC, "R1 R2 wrap");

    // R4: not-taken misses allocate nothing
    for (int s = 0; s < 16; s++) upd(mkPc(26'h0A0, s, 0), 32'h1000 + s, 1'b0);
    for (int s = 0; s < 16; s++) look(mkPc(26'h0A0, s, 0), "R4");

    // R3 / R5: allocate one taken branch per set
    for (int s = 0; s < 16; s++) upd(mkPc(26'h100, s, 0), 32'h2000 + 16 * s, 1'b1);
    for (int s = 0; s < 16; s++) begin
      look(mkPc(26'h100, s, 0), "R3");
      look(mkPc(26'h100, s, 3), "R5 low bits");
      look(mkPc(26'h101, s, 0), "R5 other tag");
    end

    // R8: fill way 1, refresh way 0, then a third tag evicts the other one
    for (int s = 0; s < 16; s++) begin
      upd(mkPc(26'h200, s, 0), 32'h3000 + s, 1'b1);
      upd(mkPc(26'h100, s, 0), 32'h2000 + 16 * s, 1'b1);
      upd(mkPc(26'h300, s, 1), 32'h4000 + s, 1'b1);
      look(mkPc(26'h100, s, 0), "R8 kept");
      look(mkPc(26'h200, s, 0), "R8 evicted");
      look(mkPc(26'h300, s, 0), "R8 new");
    end

    // R7: counter walk on one entry in set 5 (counter now 3 after refresh)
    for (int k = 0; k < 5; k++) begin
      upd(mkPc(26'h100, 5, 0), 32'h2050, 1'b0);
      look(mkPc(26'h100, 5, 0), "R7 down");
    end
    for (int k = 0; k < 5; k++) begin
      upd(mkPc(26'h100, 5, 0), 32'h2050, 1'b1);
      look(mkPc(26'h100, 5, 0), "R7 up");
    end

    // R6: not-taken hit still rewrites target
    upd(mkPc(26'h300, 7, 0), 32'h9999_0000, 1'b0);
    look(mkPc(26'h300, 7, 0), "R6");

    // R9: same-cycle allocate and lookup of the same PC
    cycle(mkPc(26'h3F0, 9, 0), 1'b1, mkPc(26'h3F0, 9, 0), 32'h7777_0000, 1'b1, "R9 same cycle");
    look(mkPc(26'h3F0, 9, 0), "R9 after");

    // Mixed sweep: four tags per set, concurrent lookup and update
    for (int k = 0; k < 3000; k++) begin
      logic [31:0] a, b;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      a = mkPc(26'h050 + 26'(lfsr[1:0]), int'(lfsr[5:2]), int'(lfsr[7:6]));
      b = mkPc(26'h050 + 26'(lfsr[9:8]), int'(lfsr[13:10]), int'(lfsr[15:14]));
      cycle(a, lfsr[16] | lfsr[17], b, {lfsr[31:18], 18'h0}, lfsr[20] | lfsr[19],
            "R2 R7 R8 R9 sweep");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule